// File: doc/BRIEF.md
# Power-Down Clock Shutdown Sequencer

This block turns a single shared control pin into a clean clock shutdown and restart. After reset the pin is read as an active-low power-good indication. Once it has been seen low, the pin is from then on read as an active-high power-down request. On a qualified request the block parks every single-ended clock low and every differential pair in a state chosen per group. Only when all of them are parked does it drop the oscillator and synthesizer enables. When the request goes away, the enables come back first, and after a fixed settling count the outputs are released.

All inputs, including the gated clocks, are sampled on the CPU reference clock. The gated clocks are treated as level inputs whose edges are found by comparing two successive samples. The sequencer is a five-state machine. WAIT_PG holds the outputs parked until power-good is seen (transition pg_seen). RUN passes the clocks through (transition pd_detected to PARK). PARK waits for all lanes to park, or forces them when the park window expires (transition all_parked to OFF). OFF clears the enables (transition pd_released to WAKE). WAKE runs the settling count (transition wake_done to RUN, or pd_detected back to OFF).

Top module: `pwrdn_seq`

## Requirements
- R1: Out of reset the pin is power-good (active low). While it has never been sampled low, the enables are on and every output is parked. After the first low sample the pin is permanently a power-down request.
- R2: The pin passes a two-flop synchronizer. Power-down is recognised only after two consecutive high synchronized samples, so a pin high for a single CPU cycle has no effect.
- R3: In RUN every gated clock output equals its input, and both output enables of every differential pair are 1.
- R4: On power-down each single-ended output is held low from its next falling edge onward, and stays low while the request lasts.
- R5: A differential group parks on the cycle its complement input is seen falling. With drive-mode bit 0 the true output is held 1 with its enable 1, and the complement enable is 0. Groups are index 0 CPU, 1 SRC, 2 DOT.
- R6: With drive-mode bit 1 a parked group has both true and complement enables at 0.
- R7: The oscillator and VCO enables fall only after every single-ended and differential lane is parked.
- R8: If a lane sees no edge, it is forced parked after PARK_MAX cycles in PARK. With all gated clocks stalled, the enables therefore fall exactly PARK_MAX+7 CPU cycles after the pin rises.
- R9: When the pin falls during OFF, the enables return 4 CPU cycles later with the outputs still parked. The outputs are released WAKE_CYC+1 cycles after the enables return.
- R10: A power-down recognised during WAKE, including in its final counting cycle, returns the block to OFF and the outputs are never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU true reference clock, samples everything |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_pgpd | input | 1 | Shared power-good / power-down pin |
| se_clk_i | input | NUM_SE | Single-ended clock levels to gate |
| dif_t_i | input | NUM_DIF | Differential true levels |
| dif_c_i | input | NUM_DIF | Differential complement levels |
| drv_mode_i | input | NUM_DIF | Per-group park mode (0: true high, 1: both tristate) |
| se_clk_o | output | NUM_SE | Gated single-ended clocks |
| dif_t_o | output | NUM_DIF | Gated differential true |
| dif_c_o | output | NUM_DIF | Gated differential complement |
| dif_t_oe_o | output | NUM_DIF | True output enable |
| dif_c_oe_o | output | NUM_DIF | Complement output enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | Synthesizer VCO enable |

## Verification
The two functions that can land in the same cycle are completion of the wake settling count and recognition of a new power-down. The bench watches for the enables to return, then raises the pin exactly three cycles later. Through the synchronizer, the qualifier and the state register, that timing makes the request reach the machine on its last WAKE cycle. The result is judged correct when the enables fall again and no differential complement enable ever rises.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_PG,
        ST_RUN,
        ST_PARK,
        ST_OFF,
        ST_WAKE
    } seq_state_t;
endpackage

// File: rtl/pdseq_pin_qual.sv
module pdseq_pin_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pg_seen_o,
    output logic pd_det_o
);
    logic sy1_q, sy2_q, sy2_d_q, pg_q, pd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy1_q   <= 1'b1;
            sy2_q   <= 1'b1;
            sy2_d_q <= 1'b1;
            pg_q    <= 1'b0;
            pd_q    <= 1'b0;
        end else begin
            sy1_q   <= pin_i;
            sy2_q   <= sy1_q;
            sy2_d_q <= sy2_q;
            pg_q    <= pg_q | ~sy2_q;
            pd_q    <= pg_q & sy2_q & sy2_d_q;
        end
    end

    assign pg_seen_o = pg_q;
    assign pd_det_o  = pd_q;

    // R1
    pg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_q |=> pg_q);

    // R2
    pd_two_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_q) |-> ($past(sy2_q, 1) && $past(sy2_q, 2)));
endmodule

// File: rtl/pdseq_park_lane.sv
module pdseq_park_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic watch_i,
    input  logic park_req_i,
    input  logic force_i,
    output logic parked_o
);
    logic watch_q, parked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            watch_q  <= 1'b0;
            parked_q <= 1'b1;
        end else begin
            watch_q <= watch_i;
            if (!park_req_i)
                parked_q <= 1'b0;
            else if (force_i || (watch_q && !watch_i))
                parked_q <= 1'b1;
        end
    end

    assign parked_o = parked_q;

    // R4
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (parked_q && park_req_i) |=> parked_q);

    // R9
    park_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !park_req_i |=> !parked_q);
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
    import pwrdn_seq_pkg::*;
#(
    parameter int PARK_MAX = 16,
    parameter int WAKE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_seen_i,
    input  logic pd_det_i,
    input  logic all_parked_i,
    output logic park_req_o,
    output logic force_park_o,
    output logic clk_en_o
);
    localparam int PCW       = $clog2(PARK_MAX + 1);
    localparam int WCW       = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
    localparam int WAKE_LAST = WAKE_CYC - 1;

    seq_state_t state_q, state_n;
    logic [PCW-1:0] park_cnt_q;
    logic [WCW-1:0] wake_cnt_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_WAIT_PG: if (pg_seen_i) state_n = ST_RUN;
            ST_RUN:     if (pd_det_i) state_n = ST_PARK;
            ST_PARK:    if (all_parked_i) state_n = ST_OFF;
            ST_OFF:     if (!pd_det_i) state_n = ST_WAKE;
            ST_WAKE: begin
                if (pd_det_i)
                    state_n = ST_OFF;
                else if (wake_cnt_q == WCW'(WAKE_LAST))
                    state_n = ST_RUN;
            end
            default:    state_n = ST_WAIT_PG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_WAIT_PG;
            park_cnt_q <= '0;
            wake_cnt_q <= '0;
        end else begin
            state_q <= state_n;
            if (state_q != ST_PARK)
                park_cnt_q <= '0;
            else if (park_cnt_q != PCW'(PARK_MAX))
                park_cnt_q <= park_cnt_q + 1'b1;
            if (state_q != ST_WAKE)
                wake_cnt_q <= '0;
            else
                wake_cnt_q <= wake_cnt_q + 1'b1;
        end
    end

    always_comb begin
        park_req_o   = (state_q != ST_RUN);
        force_park_o = (state_q == ST_WAIT_PG) ||
                       ((state_q == ST_PARK) && (park_cnt_q == PCW'(PARK_MAX)));
        clk_en_o     = (state_q != ST_OFF);
    end

    // R7
    off_after_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> all_parked_i);

    // R8
    park_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park_cnt_q <= PCW'(PARK_MAX));

    // R9
    wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && ($past(state_q) == ST_WAKE))
        |-> ($past(wake_cnt_q) == WCW'(WAKE_LAST)));

    // R10
    wake_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAKE) && pd_det_i) |=> (state_q == ST_OFF));
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
    parameter int NUM_SE   = 2,
    parameter int NUM_DIF  = 3,
    parameter int PARK_MAX = 16,
    parameter int WAKE_CYC = 8
) (
    input  logic               clk_cpu,
    input  logic               rst_n,
    input  logic               pin_pgpd,
    input  logic [NUM_SE-1:0]  se_clk_i,
    input  logic [NUM_DIF-1:0] dif_t_i,
    input  logic [NUM_DIF-1:0] dif_c_i,
    input  logic [NUM_DIF-1:0] drv_mode_i,
    output logic [NUM_SE-1:0]  se_clk_o,
    output logic [NUM_DIF-1:0] dif_t_o,
    output logic [NUM_DIF-1:0] dif_c_o,
    output logic [NUM_DIF-1:0] dif_t_oe_o,
    output logic [NUM_DIF-1:0] dif_c_oe_o,
    output logic               osc_en_o,
    output logic               vco_en_o
);
    logic pg_seen, pd_det, park_req, force_park, clk_en, all_parked;
    logic [NUM_SE-1:0]  se_parked;
    logic [NUM_DIF-1:0] dif_parked;

    pdseq_pin_qual u_qual (
        .clk       (clk_cpu),
        .rst_n     (rst_n),
        .pin_i     (pin_pgpd),
        .pg_seen_o (pg_seen),
        .pd_det_o  (pd_det)
    );

    pdseq_fsm #(.PARK_MAX(PARK_MAX), .WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk          (clk_cpu),
        .rst_n        (rst_n),
        .pg_seen_i    (pg_seen),
        .pd_det_i     (pd_det),
        .all_parked_i (all_parked),
        .park_req_o   (park_req),
        .force_park_o (force_park),
        .clk_en_o     (clk_en)
    );

    for (genvar i = 0; i < NUM_SE; i++) begin : g_se
        pdseq_park_lane u_lane (
            .clk        (clk_cpu),
            .rst_n      (rst_n),
            .watch_i    (se_clk_i[i]),
            .park_req_i (park_req),
            .force_i    (force_park),
            .parked_o   (se_parked[i])
        );
        assign se_clk_o[i] = se_parked[i] ? 1'b0 : se_clk_i[i];
    end

    for (genvar g = 0; g < NUM_DIF; g++) begin : g_dif
        pdseq_park_lane u_lane (
            .clk        (clk_cpu),
            .rst_n      (rst_n),
            .watch_i    (dif_c_i[g]),
            .park_req_i (park_req),
            .force_i    (force_park),
            .parked_o   (dif_parked[g])
        );
        always_comb begin
            if (dif_parked[g]) begin
                dif_t_o[g]    = ~drv_mode_i[g];
                dif_t_oe_o[g] = ~drv_mode_i[g];
                dif_c_o[g]    = 1'b0;
                dif_c_oe_o[g] = 1'b0;
            end else begin
                dif_t_o[g]    = dif_t_i[g];
                dif_t_oe_o[g] = 1'b1;
                dif_c_o[g]    = dif_c_i[g];
                dif_c_oe_o[g] = 1'b1;
            end
        end
    end

    assign all_parked = (&se_parked) & (&dif_parked);
    assign osc_en_o   = clk_en;
    assign vco_en_o   = clk_en;
endmodule

// File: tb/pwrdn_seq_tb_top.sv
`timescale 1ns/1ps
module pwrdn_seq_tb_top;
    localparam int NSE  = 2;
    localparam int NDIF = 3;
    localparam int PMAX = 16;
    localparam int WCYC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b1;
    logic [NSE-1:0]  se_i = '0;
    logic [NDIF-1:0] t_i = '0;
    logic [NDIF-1:0] c_i = '1;
    logic [NDIF-1:0] mode = '0;
    logic [NSE-1:0]  se_o;
    logic [NDIF-1:0] t_o, c_o, t_oe, c_oe;
    logic osc, vco;

    int errors = 0;
    int checks = 0;
    bit gen_on = 1'b0;
    logic [NDIF-1:0] c_at_edge = '1;
    logic [NDIF-1:0] c_before = '1;

    always #2 clk = ~clk;

    pwrdn_seq #(.NUM_SE(NSE), .NUM_DIF(NDIF), .PARK_MAX(PMAX), .WAKE_CYC(WCYC)) dut_i (
        .clk_cpu(clk), .rst_n(rst_n), .pin_pgpd(pin),
        .se_clk_i(se_i), .dif_t_i(t_i), .dif_c_i(c_i), .drv_mode_i(mode),
        .se_clk_o(se_o), .dif_t_o(t_o), .dif_c_o(c_o),
        .dif_t_oe_o(t_oe), .dif_c_oe_o(c_oe), .osc_en_o(osc), .vco_en_o(vco)
    );

    // clock-level generator: updates 1 ns after each rising edge
    initial begin
        int n = 0;
        forever begin
            @(posedge clk);
            c_before  = c_at_edge;
            c_at_edge = c_i;
            #1;
            if (gen_on) begin
                n++;
                if (n % 2 == 0) se_i[0] = ~se_i[0];
                if (n % 5 == 0) se_i[1] = ~se_i[1];
                for (int g = 0; g < NDIF; g++)
                    if ((n + g) % 3 == 0) begin
                        t_i[g] = ~t_i[g];
                        c_i[g] = ~t_i[g];
                    end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_parked(input string req);
        chk(se_o == '0, req, "single-ended parked low", se_o, 0);
        for (int g = 0; g < NDIF; g++) begin
            if (mode[g] == 1'b0) begin
                chk(t_o[g] && t_oe[g] && !c_oe[g], "R5", "mode0 group park",
                    {t_o[g], t_oe[g], c_oe[g]}, 3'b110);
            end else begin
                chk(!t_oe[g] && !c_oe[g], "R6", "mode1 group park",
                    {t_oe[g], c_oe[g]}, 0);
            end
        end
    endtask

    task automatic t_reset();
        mode = 3'b010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R1: never-low pin keeps enables on and outputs parked
        chk(osc && vco, "R1", "enables on before power-good", {osc, vco}, 3);
        chk_parked("R1");
    endtask

    task automatic t_power_good();
        gen_on = 1'b1;
        @(negedge clk);
        pin = 1'b0;
        repeat (7) @(negedge clk);
        // R3 pass-through
        for (int k = 0; k < 12; k++) begin
            bit ok;
            ok = (se_o == se_i) && (t_o == t_i) && (c_o == c_i) &&
                 (t_oe == '1) && (c_oe == '1);
            chk(ok, "R3", "run pass-through", {se_o, t_o, c_o}, {se_i, t_i, c_i});
            @(negedge clk);
        end
    endtask

    task automatic t_glitch();
        pin = 1'b1;
        @(negedge clk);
        pin = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == 11) begin
                // R2 single high sample ignored
                chk(osc && (c_oe == '1), "R2", "one-cycle pin pulse ignored",
                    {osc, c_oe}, 4'hF);
            end
        end
    endtask

    task automatic t_powerdown(input logic [NDIF-1:0] m);
        logic [NDIF-1:0] prev_oe;
        logic [NSE-1:0] fell;
        int off_at = -1;
        mode = m;
        prev_oe = c_oe;
        fell = '0;
        pin = 1'b1;
        for (int k = 1; k <= 45 && off_at < 0; k++) begin
            @(negedge clk);
            for (int g = 0; g < NDIF; g++)
                if (prev_oe[g] && !c_oe[g]) begin
                    // R5 park on complement falling edge, within 4 periods
                    chk(!c_at_edge[g] && c_before[g], "R5", "park at complement fall",
                        {c_before[g], c_at_edge[g]}, 2'b10);
                    chk(k <= 5 + 24, "R5", "park within 4 periods", k, 29);
                end
            prev_oe = c_oe;
            // R4 once a single-ended output went low after park, it stays low
            for (int b = 0; b < NSE; b++) begin
                if (fell[b] && se_o[b])
                    chk(1'b0, "R4", "single-ended output rose after hold", 1, 0);
                if (k > 6 && !se_i[b] && !se_o[b] && dut_i.osc_en_o) fell[b] = fell[b] | (k > 8);
            end
            if (!osc) off_at = k;
        end
        chk(off_at > 0, "R7", "enables eventually off", off_at, 1);
        // R7 parked before enables drop
        chk_parked("R7");
        chk(!vco, "R7", "vco off with oscillator", vco, 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (se_o != '0) chk(1'b0, "R4", "single-ended held low", se_o, 0);
        end
        chk(se_o == '0 && !osc, "R4", "held low during power-down", se_o, 0);
    endtask

    task automatic t_wake();
        int w = 0;
        pin = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(!osc, "R9", "enables still off", osc, 0);
        end
        @(negedge clk);
        // R9 enables first, outputs still parked
        chk(osc && vco, "R9", "enables back 4 cycles after pin fall", {osc, vco}, 3);
        chk(c_oe == '0, "R9", "outputs parked at enable return", c_oe, 0);
        while (!c_oe[0] && w < 40) begin
            @(negedge clk);
            w++;
        end
        chk(w == WCYC + 1, "R9", "release delay", w, WCYC + 1);
    endtask

    task automatic t_stall();
        gen_on = 1'b0;
        repeat (3) @(negedge clk);
        pin = 1'b1;
        repeat (PMAX + 6) @(negedge clk);
        // R8 forced park timing
        chk(osc, "R8", "enables on one cycle before forced shutdown", osc, 1);
        @(negedge clk);
        chk(!osc, "R8", "enables off at PARK_MAX+7", osc, 0);
        chk_parked("R8");
        gen_on = 1'b1;
    endtask

    task automatic t_collision();
        int k = 0;
        pin = 1'b1;
        while (osc && k < 60) begin
            @(negedge clk);
            k++;
        end
        chk(!osc, "R10", "setup shutdown reached", osc, 0);
        pin = 1'b0;
        k = 0;
        while (!osc && k < 20) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
        pin = 1'b1;
        for (int j = 0; j < 14; j++) begin
            @(negedge clk);
            if (c_oe != '0) chk(1'b0, "R10", "outputs released despite request", c_oe, 0);
        end
        // R10 last wake cycle collides with power-down
        chk(!osc && c_oe == '0, "R10", "back in shutdown", {osc, c_oe}, 0);
    endtask

    initial begin
        t_reset();
        t_power_good();
        t_glitch();
        t_powerdown(3'b010);
        t_wake();
        repeat (5) @(negedge clk);
        t_powerdown(3'b101);
        t_wake();
        repeat (5) @(negedge clk);
        t_stall();
        t_wake();
        repeat (5) @(negedge clk);
        t_collision();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule